// File: doc/BRIEF.md
# Disk Controller Register and Interrupt Block

This block is the software-visible face of a small moving-head disk controller. It decodes aligned 16-bit word accesses that fall inside a fixed window of twenty words. Inside that window it keeps a command/status word, a drive attention word, an error word, a transfer word count, a transfer bus address and a target cylinder. From these it drives one level-sensitive interrupt request. Seeking, data movement and error detection live elsewhere. They reach this block only through strobes: operation complete, per-drive attention, error bits and the selected unit's current cylinder.

Software starts an operation by writing a function code with the start bit set. Function code 0 with the start bit set is the controller-reset command. It wipes the data registers and reports completion at once. The interrupt-enable setting survives it, so software can detect the controller by enabling interrupts, issuing the command and waiting for the request. Attention bits are cleared by writing ones. Clearing them lowers the request only when no other reason for it is left.

Top module: `dskc_regif`

## Requirements
- R1: An access at an odd byte address, or outside the window from base 17776710 (octal) through base+46 (octal), changes no register. A read there returns 0, and `bus_sel_o` stays low in the following cycle. An aligned access inside the window raises `bus_sel_o` for one cycle.
- R2: The word offsets 14 to 46 (octal) read as zero and ignore writes. The error word at offset 04 is read-only: bits are OR-ed in from `err_set_i` and writes to it are ignored.
- R3: The cylinder word at offset 12 holds a writable target cylinder in bits 7:0. Bits 15:8 always read `cur_cyl_i`, and writes to them are ignored.
- R4: The command/status word at offset 00 has start in bit 0, function in bits 3:1, interrupt-enable in bit 6, done in bit 7 and attention-interrupt-enable in bit 8. Writing start with a nonzero function loads the fields, sets start and clears done. A one-cycle `op_done_i` then sets done and clears start.
- R5: When done goes from 0 to 1 through `op_done_i` while interrupt-enable is 1, `irq_o` is 1 from the next cycle. With interrupt-enable 0, no request is raised.
- R6: Writing start with function 0 (controller reset) clears the attention, error, word count, bus address and target cylinder registers. It loads the command/status word with done set, interrupt-enable unchanged and all other bits zero.
- R7: After a controller reset, `irq_o` equals the interrupt-enable bit it kept.
- R8: A write to the attention word at offset 02 clears each attention bit (bit n for drive n) whose data bit is 1 and leaves the others unchanged. `attn_set_i` sets attention bits.
- R9: An attention-clearing write lowers `irq_o` only when all of these hold: no attention bit remains, attention-interrupt-enable is 1, and interrupt-enable or done is 0. Otherwise the request is held.
- R10: An `attn_set_i` pulse while attention-interrupt-enable is 1 raises `irq_o` in the next cycle. While it is 0, the attention bit is recorded without a request.
- R11: A one-cycle `irq_ack_i` lowers `irq_o` unless a new cause arrives in the same cycle.
- R12: Synchronous `rst_i` (bus init) clears every register, including interrupt-enable and done, and lowers `irq_o`.
- R13: Read data for a word in the window appears on `bus_rdata_o` in the cycle after the read and reflects writes completed earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high bus init |
| bus_addr_i | input | ADDR_W (22) | Byte address of the access |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| bus_sel_o | output | 1 | Registered: previous access hit the window |
| op_done_i | input | 1 | One-cycle operation-complete strobe |
| attn_set_i | input | N_DRV (8) | Per-drive attention set strobes |
| err_set_i | input | 16 | Error bits to OR into the error word |
| cur_cyl_i | input | 8 | Current cylinder of the selected unit |
| irq_ack_i | input | 1 | One-cycle interrupt acknowledge |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest state to reach is an attention clear while interrupt-enable, done and attention-interrupt-enable are all 1. In that state the clear must leave the request standing. The bench gets there in steps. It first sets interrupt-enable with a plain command write. It then issues a controller reset, which sets done and keeps interrupt-enable. Next it makes a command write without start to turn on attention-interrupt-enable while done stays set. Finally it pulses an attention strobe and clears that bit. A second path checks that a controller reset uses the interrupt-enable value held before the write, not the value carried in the written word.

// File: rtl/dskc_pkg.sv
package dskc_pkg;

  localparam int DW    = 16;
  localparam int FN_W  = 3;
  localparam int IDX_W = 5;

  // word indices inside the window (byte offset / 2)
  localparam logic [IDX_W-1:0] IX_CS = 5'd0;
  localparam logic [IDX_W-1:0] IX_DS = 5'd1;
  localparam logic [IDX_W-1:0] IX_ER = 5'd2;
  localparam logic [IDX_W-1:0] IX_WC = 5'd3;
  localparam logic [IDX_W-1:0] IX_BA = 5'd4;
  localparam logic [IDX_W-1:0] IX_CA = 5'd5;

  // command/status bit positions
  localparam int B_GO   = 0;
  localparam int B_FN   = 1;
  localparam int B_IE   = 6;
  localparam int B_DONE = 7;
  localparam int B_AIE  = 8;

  localparam logic [FN_W-1:0] FN_CTL_RESET = '0;

  typedef struct packed {
    logic            go;
    logic [FN_W-1:0] fn;
    logic            ie;
    logic            aie;
  } cs_wr_t;

  typedef struct packed {
    logic            go;
    logic [FN_W-1:0] fn;
    logic            ie;
    logic            done;
    logic            aie;
  } cs_t;

endpackage

// File: rtl/dskc_addr_dec.sv
module dskc_addr_dec
  import dskc_pkg::*;
#(
  parameter int                ADDR_W  = 22,
  parameter logic [ADDR_W-1:0] BASE    = 22'o17776710,
  parameter int                N_WORDS = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(2 * N_WORDS);

  logic [ADDR_W-1:0] delta;

  assign delta = addr_i - BASE;
  assign hit_o = (addr_i >= BASE) && (delta < SPAN) && !addr_i[0];
  assign idx_o = delta[IDX_W:1];

endmodule

// File: rtl/dskc_csr_ctl.sv
module dskc_csr_ctl
  import dskc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_i,
  input  logic   cs_we_i,
  input  cs_wr_t cs_wd_i,
  input  logic   op_done_i,
  input  logic   irq_ack_i,
  input  logic   attn_evt_i,
  input  logic   ds_we_i,
  input  logic   ds_empty_i,
  output cs_t    cs_o,
  output logic   ctl_rst_o,
  output logic   irq_o
);

  cs_t  cs_q;
  logic irq_q;
  logic done_rise;
  logic irq_set;
  logic w1c_drop;

  assign ctl_rst_o = cs_we_i && cs_wd_i.go && (cs_wd_i.fn == FN_CTL_RESET);
  assign done_rise = !cs_we_i && op_done_i && !cs_q.done;
  assign irq_set   = (done_rise && cs_q.ie) || (attn_evt_i && cs_q.aie);
  assign w1c_drop  = ds_we_i && ds_empty_i && cs_q.aie
                     && (!cs_q.ie || !cs_q.done);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cs_q <= '0;
    end else if (ctl_rst_o) begin
      cs_q.go   <= 1'b0;
      cs_q.fn   <= '0;
      cs_q.aie  <= 1'b0;
      cs_q.done <= 1'b1;
    end else if (cs_we_i) begin
      cs_q.fn  <= cs_wd_i.fn;
      cs_q.ie  <= cs_wd_i.ie;
      cs_q.aie <= cs_wd_i.aie;
      if (cs_wd_i.go) begin
        cs_q.go   <= 1'b1;
        cs_q.done <= 1'b0;
      end
    end else if (done_rise) begin
      cs_q.done <= 1'b1;
      cs_q.go   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                      irq_q <= 1'b0;
    else if (ctl_rst_o)             irq_q <= cs_q.ie;
    else if (irq_set)               irq_q <= 1'b1;
    else if (w1c_drop || irq_ack_i) irq_q <= 1'b0;
  end

  assign cs_o  = cs_q;
  assign irq_o = irq_q;

endmodule

// File: rtl/dskc_data_regs.sv
module dskc_data_regs
  import dskc_pkg::*;
#(
  parameter int N_DRV = 8,
  parameter int CYL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               ctl_rst_i,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [DW-1:0]      wdata_i,
  input  logic [N_DRV-1:0]   attn_set_i,
  input  logic [DW-1:0]      err_set_i,
  input  logic [DW-CYL_W-1:0] cur_cyl_i,
  output logic [DW-1:0]      ds_o,
  output logic [DW-1:0]      er_o,
  output logic [DW-1:0]      wc_o,
  output logic [DW-1:0]      ba_o,
  output logic [DW-1:0]      ca_o,
  output logic               ds_empty_o
);

  logic              clr;
  logic              ds_we;
  logic [N_DRV-1:0]  attn_q;
  logic [N_DRV-1:0]  attn_d;
  logic [DW-1:0]     er_q;
  logic [DW-1:0]     wc_q;
  logic [DW-1:0]     ba_q;
  logic [CYL_W-1:0]  ca_q;

  assign clr   = rst_i || ctl_rst_i;
  assign ds_we = we_i && (idx_i == IX_DS);

  for (genvar g = 0; g < N_DRV; g++) begin : g_drv
    assign attn_d[g] = attn_set_i[g] | (attn_q[g] & ~(ds_we & wdata_i[g]));
    always_ff @(posedge clk_i) begin
      if (clr) attn_q[g] <= 1'b0;
      else     attn_q[g] <= attn_d[g];
    end
  end

  assign ds_empty_o = (attn_d == '0);

  always_ff @(posedge clk_i) begin
    if (clr) begin
      er_q <= '0;
      wc_q <= '0;
      ba_q <= '0;
      ca_q <= '0;
    end else begin
      er_q <= er_q | err_set_i;
      if (we_i && idx_i == IX_WC) wc_q <= wdata_i;
      if (we_i && idx_i == IX_BA) ba_q <= wdata_i;
      if (we_i && idx_i == IX_CA) ca_q <= wdata_i[CYL_W-1:0];
    end
  end

  assign ds_o = DW'(attn_q);
  assign er_o = er_q;
  assign wc_o = wc_q;
  assign ba_o = ba_q;
  assign ca_o = {cur_cyl_i, ca_q};

endmodule

// File: rtl/dskc_regif.sv
module dskc_regif
  import dskc_pkg::*;
#(
  parameter int                ADDR_W  = 22,
  parameter logic [ADDR_W-1:0] BASE    = 22'o17776710,
  parameter int                N_WORDS = 20,
  parameter int                N_DRV   = 8,
  parameter int                CYL_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic                bus_rd_i,
  input  logic                bus_wr_i,
  input  logic [DW-1:0]       bus_wdata_i,
  output logic [DW-1:0]       bus_rdata_o,
  output logic                bus_sel_o,
  input  logic                op_done_i,
  input  logic [N_DRV-1:0]    attn_set_i,
  input  logic [DW-1:0]       err_set_i,
  input  logic [DW-CYL_W-1:0] cur_cyl_i,
  input  logic                irq_ack_i,
  output logic                irq_o
);

  logic             hit;
  logic [IDX_W-1:0] idx;
  logic             wr_en;
  logic             cs_we;
  logic             ds_we;
  logic             ds_empty;
  logic             ctl_rst;
  cs_wr_t           cs_wd;
  cs_t              cs_w;
  logic [DW-1:0]    cs_word;
  logic [DW-1:0]    ds_w, er_w, wc_w, ba_w, ca_w;
  logic [DW-1:0]    rd_mux;
  logic [DW-1:0]    rdata_q;
  logic             sel_q;

  dskc_addr_dec #(
    .ADDR_W (ADDR_W),
    .BASE   (BASE),
    .N_WORDS(N_WORDS)
  ) u_dec (
    .addr_i(bus_addr_i),
    .hit_o (hit),
    .idx_o (idx)
  );

  assign wr_en = hit && bus_wr_i;
  assign cs_we = wr_en && (idx == IX_CS);
  assign ds_we = wr_en && (idx == IX_DS);

  assign cs_wd.go  = bus_wdata_i[B_GO];
  assign cs_wd.fn  = bus_wdata_i[B_FN +: FN_W];
  assign cs_wd.ie  = bus_wdata_i[B_IE];
  assign cs_wd.aie = bus_wdata_i[B_AIE];

  dskc_csr_ctl u_csr (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cs_we_i   (cs_we),
    .cs_wd_i   (cs_wd),
    .op_done_i (op_done_i),
    .irq_ack_i (irq_ack_i),
    .attn_evt_i(|attn_set_i),
    .ds_we_i   (ds_we),
    .ds_empty_i(ds_empty),
    .cs_o      (cs_w),
    .ctl_rst_o (ctl_rst),
    .irq_o     (irq_o)
  );

  dskc_data_regs #(
    .N_DRV(N_DRV),
    .CYL_W(CYL_W)
  ) u_data (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .ctl_rst_i (ctl_rst),
    .we_i      (wr_en),
    .idx_i     (idx),
    .wdata_i   (bus_wdata_i),
    .attn_set_i(attn_set_i),
    .err_set_i (err_set_i),
    .cur_cyl_i (cur_cyl_i),
    .ds_o      (ds_w),
    .er_o      (er_w),
    .wc_o      (wc_w),
    .ba_o      (ba_w),
    .ca_o      (ca_w),
    .ds_empty_o(ds_empty)
  );

  always_comb begin
    cs_word                  = '0;
    cs_word[B_GO]            = cs_w.go;
    cs_word[B_FN +: FN_W]    = cs_w.fn;
    cs_word[B_IE]            = cs_w.ie;
    cs_word[B_DONE]          = cs_w.done;
    cs_word[B_AIE]           = cs_w.aie;
  end

  always_comb begin
    case (idx)
      IX_CS:   rd_mux = cs_word;
      IX_DS:   rd_mux = ds_w;
      IX_ER:   rd_mux = er_w;
      IX_WC:   rd_mux = wc_w;
      IX_BA:   rd_mux = ba_w;
      IX_CA:   rd_mux = ca_w;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q <= '0;
      sel_q   <= 1'b0;
    end else begin
      sel_q   <= hit && (bus_rd_i || bus_wr_i);
      rdata_q <= (hit && bus_rd_i) ? rd_mux : '0;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign bus_sel_o   = sel_q;

endmodule

// File: rtl/dskc_regif_chk.sv
module dskc_regif_chk #(
  parameter int                ADDR_W = 22,
  parameter logic [ADDR_W-1:0] BASE   = 22'o17776710,
  parameter int                N_DRV  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              rd,
  input logic              wr,
  input logic [3:0]        wlo,
  input logic              op_done,
  input logic              ack,
  input logic [N_DRV-1:0]  attn_set,
  input logic              irq,
  input logic              sel,
  input logic [15:0]       rdata,
  input logic              done,
  input logic              ie
);

  logic ctl_rst_req;
  assign ctl_rst_req = wr && (addr == BASE) && wlo[0] && (wlo[3:1] == 3'b000);

  p_odd_addr_r1: assert property (@(posedge clk) disable iff (rst)
    (rd || wr) && addr[0] |=> !sel && (rdata == 16'h0000));

  p_done_irq_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) && ie |-> irq);

  p_ctlrst_keep_r6: assert property (@(posedge clk) disable iff (rst)
    ctl_rst_req |=> done && (ie == $past(ie)));

  p_ctlrst_irq_r7: assert property (@(posedge clk) disable iff (rst)
    ctl_rst_req |=> irq == $past(ie));

  p_ack_drop_r11: assert property (@(posedge clk) disable iff (rst)
    ack && !op_done && (attn_set == '0) && !wr |=> !irq);

  p_init_clear_r12: assert property (@(posedge clk)
    rst |=> !irq && !ie && !done);

endmodule

bind dskc_regif dskc_regif_chk #(
  .ADDR_W(ADDR_W),
  .BASE  (BASE),
  .N_DRV (N_DRV)
) chk_i (
  .clk     (clk_i),
  .rst     (rst_i),
  .addr    (bus_addr_i),
  .rd      (bus_rd_i),
  .wr      (bus_wr_i),
  .wlo     (bus_wdata_i[3:0]),
  .op_done (op_done_i),
  .ack     (irq_ack_i),
  .attn_set(attn_set_i),
  .irq     (irq_o),
  .sel     (bus_sel_o),
  .rdata   (bus_rdata_o),
  .done    (cs_w.done),
  .ie      (cs_w.ie)
);

// File: tb/dskc_regif_tb_top.sv
module dskc_regif_tb_top;

  localparam logic [21:0] BASE = 22'o17776710;
  localparam int NV = 9;
  // {byte offset (6), write data (16), expected read (16)}
  localparam logic [37:0] VEC [NV] = '{
    {6'o06, 16'h1234, 16'h1234},
    {6'o10, 16'hFFFE, 16'hFFFE},
    {6'o12, 16'h00A5, 16'h3CA5},
    {6'o12, 16'hFF5A, 16'h3C5A},
    {6'o14, 16'hFFFF, 16'h0000},
    {6'o42, 16'hFFFF, 16'h0000},
    {6'o46, 16'hFFFF, 16'h0000},
    {6'o04, 16'hFFFF, 16'h0000},
    {6'o00, 16'h0140, 16'h0140}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [21:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_sel;
  logic        op_done = 1'b0;
  logic [7:0]  attn_set = '0;
  logic [15:0] err_set = '0;
  logic [7:0]  cur_cyl = 8'h3C;
  logic        irq_ack = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dskc_regif dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .bus_addr_i (bus_addr),
    .bus_rd_i   (bus_rd),
    .bus_wr_i   (bus_wr),
    .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata),
    .bus_sel_o  (bus_sel),
    .op_done_i  (op_done),
    .attn_set_i (attn_set),
    .err_set_i  (err_set),
    .cur_cyl_i  (cur_cyl),
    .irq_ack_i  (irq_ack),
    .irq_o      (irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [21:0] a, input logic w, input logic [15:0] d,
                        output logic [15:0] rd, output logic sel);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = !w; bus_wdata = d;
    @(negedge clk);
    rd = bus_rdata; sel = bus_sel;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [5:0] off, input logic [15:0] d);
    logic [15:0] r; logic s;
    access(BASE + 22'(off), 1'b1, d, r, s);
  endtask

  task automatic rdw(input logic [5:0] off, output logic [15:0] r);
    logic s;
    access(BASE + 22'(off), 1'b0, 16'h0, r, s);
  endtask

  task automatic init();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic pulse_attn(input logic [7:0] m);
    @(negedge clk); attn_set = m;
    @(negedge clk); attn_set = '0;
  endtask

  task automatic pulse_err(input logic [15:0] m);
    @(negedge clk); err_set = m;
    @(negedge clk); err_set = '0;
  endtask

  function automatic string vtag(input logic [5:0] off);
    if (off == 6'o12) return "R3";
    if (off == 6'o04 || off >= 6'o14) return "R2";
    return "R13";
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] r; logic s;
    repeat (2) @(negedge clk);
    rst = 1'b0;

    // reset state (R12)
    rdw(6'o00, r); chk("R12 cs after init", r, 16'h0000);
    rdw(6'o02, r); chk("R12 ds after init", r, 16'h0000);
    chk("R12 irq after init", 16'(irq), 16'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [5:0]  off;
      logic [15:0] wd, ex;
      {off, wd, ex} = VEC[i];
      wr(off, wd);
      access(BASE + 22'(off), 1'b0, 16'h0, r, s);
      chk($sformatf("%s vector %0d data", vtag(off), i), r, ex);
      chk($sformatf("R1 vector %0d sel", i), 16'(s), 16'h1);
    end

    // R1: odd and out-of-window accesses
    init();
    wr(6'o06, 16'h00AA);
    access(BASE + 22'd7, 1'b1, 16'h5555, r, s);
    chk("R1 odd write sel", 16'(s), 16'h0);
    access(BASE + 22'd7, 1'b0, 16'h0, r, s);
    chk("R1 odd read data", r, 16'h0000);
    chk("R1 odd read sel", 16'(s), 16'h0);
    access(BASE + 22'o50, 1'b1, 16'h5555, r, s);
    chk("R1 beyond window sel", 16'(s), 16'h0);
    access(BASE - 22'd2, 1'b0, 16'h0, r, s);
    chk("R1 below window sel", 16'(s), 16'h0);
    rdw(6'o06, r); chk("R1 wc untouched", r, 16'h00AA);

    // R4/R5: start, complete, interrupt
    wr(6'o00, 16'h0043);
    rdw(6'o00, r); chk("R4 cs after start", r, 16'h0043);
    pulse_done();
    chk("R5 irq on done with ie", 16'(irq), 16'h1);
    rdw(6'o00, r); chk("R4 cs after done", r, 16'h00C2);
    pulse_ack();
    chk("R11 irq after ack", 16'(irq), 16'h0);
    wr(6'o00, 16'h0003);
    pulse_done();
    chk("R5 no irq without ie", 16'(irq), 16'h0);
    rdw(6'o00, r); chk("R4 cs done no ie", r, 16'h0082);

    // R6/R7: controller reset keeps previous ie
    wr(6'o00, 16'h0040);
    wr(6'o06, 16'h0005); wr(6'o10, 16'h0007); wr(6'o12, 16'h0011);
    pulse_err(16'h8001);
    rdw(6'o04, r); chk("R2 error bits set", r, 16'h8001);
    wr(6'o00, 16'h0001);
    chk("R7 irq after reset with ie", 16'(irq), 16'h1);
    rdw(6'o00, r); chk("R6 cs after reset", r, 16'h00C0);
    rdw(6'o06, r); chk("R6 wc cleared", r, 16'h0000);
    rdw(6'o10, r); chk("R6 ba cleared", r, 16'h0000);
    rdw(6'o12, r); chk("R6 ca cleared", r, 16'h3C00);
    rdw(6'o04, r); chk("R6 er cleared", r, 16'h0000);

    // R10/R7: attention with aie, then reset without ie
    pulse_ack();
    wr(6'o00, 16'h0100);
    rdw(6'o00, r); chk("R4 non-start write keeps done", r, 16'h0180);
    pulse_attn(8'h04);
    chk("R10 irq on attention", 16'(irq), 16'h1);
    rdw(6'o02, r); chk("R8 attention recorded", r, 16'h0004);
    wr(6'o00, 16'h0001);
    chk("R7 irq low after reset without ie", 16'(irq), 16'h0);
    rdw(6'o00, r); chk("R6 cs reset no ie", r, 16'h0080);
    rdw(6'o02, r); chk("R6 ds cleared", r, 16'h0000);

    // R8/R9: write-one-to-clear, partial then full
    init();
    wr(6'o00, 16'h0100);
    pulse_attn(8'h05);
    chk("R10 irq attn pair", 16'(irq), 16'h1);
    wr(6'o02, 16'h0001);
    rdw(6'o02, r); chk("R8 partial clear", r, 16'h0004);
    chk("R9 irq held with attn left", 16'(irq), 16'h1);
    wr(6'o02, 16'h0004);
    rdw(6'o02, r); chk("R8 full clear", r, 16'h0000);
    chk("R9 irq dropped", 16'(irq), 16'h0);

    // R9: ie and done both set keep the request
    init();
    wr(6'o00, 16'h0040);
    wr(6'o00, 16'h0001);
    wr(6'o00, 16'h0140);
    rdw(6'o00, r); chk("R9 setup cs", r, 16'h01C0);
    pulse_attn(8'h02);
    wr(6'o02, 16'h0002);
    rdw(6'o02, r); chk("R8 cleared with ie done", r, 16'h0000);
    chk("R9 irq held by ie and done", 16'(irq), 16'h1);
    pulse_ack();
    chk("R11 ack clears", 16'(irq), 16'h0);

    // R10: no aie, no request
    init();
    pulse_attn(8'h08);
    chk("R10 no irq without aie", 16'(irq), 16'h0);
    rdw(6'o02, r); chk("R10 attn still recorded", r, 16'h0008);

    // R12: bus init clears ie and irq
    wr(6'o00, 16'h0043);
    pulse_done();
    chk("R12 setup irq", 16'(irq), 16'h1);
    init();
    chk("R12 irq after init", 16'(irq), 16'h0);
    rdw(6'o00, r); chk("R12 cs after init", r, 16'h0000);

    summary();
  end

endmodule